// File: doc/BRIEF.md
# Double-Banked Window Configuration Registers with Frame-Boundary Commit

This block holds the configuration words of a display controller that composes five windows. Every window owns a small group of registers, and each register exists twice. Software always writes the staging copy. The live copy, which drives the pixel pipeline, is loaded from the staging copy only at the vertical sync pulse, which is also the point where frame fetch begins. A mid-frame reconfiguration therefore never shows up half-applied on screen.

Each window has a hold bit in a shared hold word. While a window's hold bit is set, its staged values stay pending across any number of sync pulses. Software sets the hold bits, updates several registers, then clears the hold bits, and the whole group lands together at the next sync. Bit 0 of a window's first register is that window's enable. Because it is staged like any other field, a cleared enable keeps the window live until the next sync. A global control word carries an immediate output enable and a frame-synchronous output enable. The video output runs only when both are set.

Each window slice tracks its commit state with a three-state machine. The states are:
- CLEAN: staging and live copies agree.
- PENDING: a write is waiting and the hold bit is clear.
- HELD: a write is waiting and the hold bit is set.

The transitions are:
- CLEAN→PENDING on a write with the hold bit clear.
- CLEAN→HELD on a write with the hold bit set.
- PENDING→CLEAN on a sync with the hold bit clear and no write in the same cycle.
- PENDING→HELD when the hold bit is set.
- HELD→PENDING when the hold bit clears and no sync arrives, or when a sync and a write arrive together.
- HELD→CLEAN when the hold bit clears in a cycle with a sync and no write.

Top module: `shadow_regs`

Address layout: the top address bit selects global space (1) or window space (0). In window space, the next bits hold the window index and the lowest bits hold the register index. In global space the index selects one of three words:
- 0: control. Bit 0 is the immediate enable; bit 1 is the frame-synchronous enable.
- 1: hold word. Bit w belongs to window w.
- 2: read-only status. Bit w belongs to window w.

## Requirements
- R1: After reset, every live register, every staging register, the hold word, the status word and both control bits read or drive 0, and `video_on` is 0.
- R2: A write to window register (w,r) changes the staging copy, and a read of that address returns it at once. The live output of that register does not change before a sync pulse.
- R3: On a clock where `vsync` is high and window w has a pending write and its hold bit is clear, all of window w's live registers take the staging values from the following cycle. With `vsync` low, live registers never change.
- R4: On a sync, a window whose hold bit (bit w of global word 1) is set keeps its live values, while windows without a set hold bit commit.
- R5: Values held back by a hold bit commit at the first sync after that bit is cleared, and not before.
- R6: `win_en[w]` follows bit 0 of the live copy of window w register 0. After software clears it, `win_en[w]` stays 1 until the next committing sync.
- R7: A window write in the same clock as `vsync` updates the staging copy, is not committed by that sync, and is committed by the next one.
- R8: Status bit w (global word 2) is 1 from the cycle after a write to window w until the cycle after the sync that commits it, and 0 otherwise.
- R9: `video_on` is the AND of the immediate enable (control bit 0, effective the cycle after the write) and the live frame-synchronous enable (control bit 1, copied from its staging bit at every sync, regardless of hold bits). Writing 0 to the control word drops `video_on` in the next cycle.
- R10: Writes to a window index of 5 or more, or to a global index other than 0 and 1, change nothing. Reads of such addresses and of undefined control bits return 0.
- R11: A read of global word 1 returns the hold bits as written, and they take effect on the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 32 | Combinational read data (staging copy or global word) |
| vsync | input | 1 | One-cycle frame boundary pulse |
| win_regs | output | 640 | Live registers; window w register r at bits [(w*4+r)*32 +: 32] |
| win_en | output | 5 | Live enable bit of each window |
| video_on | output | 1 | Global output enable |

## Verification
The hardest case is a window that gets a write, a hold bit and a sync pulse in overlapping cycles. This includes a write landing in the sync clock of a window that is already pending, and a hold bit clearing in the same cycle a sync arrives. Directed sequences build the hold-then-release pattern and the same-clock write on purpose. Seeded random traffic then mixes writes into the hold word with frequent sync pulses, so hold bits change state right around sync pulses many times. Every cycle is compared against a bench model of the staging copies, live copies, hold bits and pending flags.

// File: rtl/shadow_regs_pkg.sv
package shadow_regs_pkg;

    typedef enum logic [1:0] {
        W_CLEAN   = 2'd0,
        W_PENDING = 2'd1,
        W_HELD    = 2'd2
    } win_state_e;

    localparam int CTRL_IMM_BIT  = 0;
    localparam int CTRL_SYNC_BIT = 1;
    localparam int WIN_EN_BIT    = 0;

    localparam int GIDX_CTRL = 0;
    localparam int GIDX_HOLD = 1;
    localparam int GIDX_STAT = 2;

endpackage

// File: rtl/win_bank.sv
module win_bank
    import shadow_regs_pkg::*;
#(
    parameter int NREG = 4,
    parameter int DW   = 32,
    localparam int RB  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [RB-1:0]        wr_reg_i,
    input  logic [DW-1:0]        wr_data_i,
    input  logic                 vsync_i,
    input  logic                 hold_i,
    input  logic [RB-1:0]        rd_reg_i,
    output logic [DW-1:0]        rd_data_o,
    output logic [NREG*DW-1:0]   active_o,
    output logic                 pending_o
);

    logic [DW-1:0] stage_q  [NREG];
    logic [DW-1:0] live_q   [NREG];
    logic [NREG*DW-1:0] stage_flat;
    win_state_e state_q, state_d;
    logic commit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_CLEAN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_CLEAN: begin
                if (wr_i) state_d = hold_i ? W_HELD : W_PENDING;
            end
            W_PENDING: begin
                if (vsync_i && !hold_i) state_d = wr_i ? W_PENDING : W_CLEAN;
                else if (hold_i)        state_d = W_HELD;
            end
            W_HELD: begin
                if (!hold_i) state_d = (vsync_i && !wr_i) ? W_CLEAN : W_PENDING;
            end
            default: state_d = W_CLEAN;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        pending_o = (state_q != W_CLEAN);
        commit    = vsync_i && !hold_i && (state_q != W_CLEAN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) stage_q[r] <= '0;
        end else if (wr_i) begin
            stage_q[wr_reg_i] <= wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) live_q[r] <= '0;
        end else if (commit) begin
            for (int r = 0; r < NREG; r++) live_q[r] <= stage_q[r];
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_flat
            assign active_o[g*DW +: DW]   = live_q[g];
            assign stage_flat[g*DW +: DW] = stage_q[g];
        end
    endgenerate

    assign rd_data_o = stage_q[rd_reg_i];

    AST_CLEAN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_CLEAN) |-> (stage_flat == active_o)); // R8
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(active_o)); // R4
    AST_NO_SYNC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_i |=> $stable(active_o)); // R3
    AST_SAME_CLOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_i && wr_i && state_q == W_CLEAN) |=> (state_q != W_CLEAN)); // R7

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import shadow_regs_pkg::*;
#(
    parameter int NWIN = 5,
    parameter int DW   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync_i,
    input  logic             wr_ctrl_i,
    input  logic [1:0]       ctrl_bits_i,
    input  logic             wr_hold_i,
    input  logic [NWIN-1:0]  hold_bits_i,
    output logic [NWIN-1:0]  hold_o,
    output logic [DW-1:0]    ctrl_rd_o,
    output logic             video_on_o
);

    logic imm_q, sync_stage_q, sync_live_q;
    logic [NWIN-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_q        <= 1'b0;
            sync_stage_q <= 1'b0;
            sync_live_q  <= 1'b0;
            hold_q       <= '0;
        end else begin
            if (vsync_i)   sync_live_q <= sync_stage_q;
            if (wr_ctrl_i) begin
                imm_q        <= ctrl_bits_i[CTRL_IMM_BIT];
                sync_stage_q <= ctrl_bits_i[CTRL_SYNC_BIT];
            end
            if (wr_hold_i) hold_q <= hold_bits_i;
        end
    end

    always_comb begin
        ctrl_rd_o                = '0;
        ctrl_rd_o[CTRL_IMM_BIT]  = imm_q;
        ctrl_rd_o[CTRL_SYNC_BIT] = sync_stage_q;
    end

    assign hold_o     = hold_q;
    assign video_on_o = imm_q & sync_live_q;

    AST_CTRL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && !ctrl_bits_i[CTRL_IMM_BIT]) |=> !video_on_o); // R9
    AST_SYNC_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_i |=> $stable(sync_live_q)); // R9

endmodule

// File: rtl/shadow_regs.sv
module shadow_regs
    import shadow_regs_pkg::*;
#(
    parameter int NWIN = 5,
    parameter int NREG = 4,
    parameter int DW   = 32,
    localparam int RB  = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int WB  = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int GI  = RB + WB,
    localparam int AW  = GI + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [AW-1:0]            rd_addr,
    output logic [DW-1:0]            rd_data,
    input  logic                     vsync,
    output logic [NWIN*NREG*DW-1:0]  win_regs,
    output logic [NWIN-1:0]          win_en,
    output logic                     video_on
);

    localparam logic [GI-1:0] A_CTRL = GI'(GIDX_CTRL);
    localparam logic [GI-1:0] A_HOLD = GI'(GIDX_HOLD);
    localparam logic [GI-1:0] A_STAT = GI'(GIDX_STAT);

    logic            wr_glb, rd_glb;
    logic [WB-1:0]   wr_win, rd_win;
    logic [RB-1:0]   wr_reg, rd_reg;
    logic [GI-1:0]   wr_gidx, rd_gidx;
    logic [NWIN-1:0] hold, pend;
    logic [DW-1:0]   ctrl_rd;
    logic [DW-1:0]   bank_rd [NWIN];

    assign wr_glb  = wr_addr[AW-1];
    assign wr_gidx = wr_addr[GI-1:0];
    assign wr_win  = wr_addr[GI-1:RB];
    assign wr_reg  = wr_addr[RB-1:0];
    assign rd_glb  = rd_addr[AW-1];
    assign rd_gidx = rd_addr[GI-1:0];
    assign rd_win  = rd_addr[GI-1:RB];
    assign rd_reg  = rd_addr[RB-1:0];

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            logic hit;
            assign hit = wr_en && !wr_glb && (wr_win == WB'(w));
            win_bank #(.NREG(NREG), .DW(DW)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_i      (hit),
                .wr_reg_i  (wr_reg),
                .wr_data_i (wr_data),
                .vsync_i   (vsync),
                .hold_i    (hold[w]),
                .rd_reg_i  (rd_reg),
                .rd_data_o (bank_rd[w]),
                .active_o  (win_regs[w*NREG*DW +: NREG*DW]),
                .pending_o (pend[w])
            );
            assign win_en[w] = win_regs[w*NREG*DW + WIN_EN_BIT];
        end
    endgenerate

    frame_ctrl #(.NWIN(NWIN), .DW(DW)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .vsync_i     (vsync),
        .wr_ctrl_i   (wr_en && wr_glb && wr_gidx == A_CTRL),
        .ctrl_bits_i (wr_data[1:0]),
        .wr_hold_i   (wr_en && wr_glb && wr_gidx == A_HOLD),
        .hold_bits_i (wr_data[NWIN-1:0]),
        .hold_o      (hold),
        .ctrl_rd_o   (ctrl_rd),
        .video_on_o  (video_on)
    );

    always_comb begin
        rd_data = '0;
        if (rd_glb) begin
            if (rd_gidx == A_CTRL)      rd_data = ctrl_rd;
            else if (rd_gidx == A_HOLD) rd_data = {{(DW-NWIN){1'b0}}, hold};
            else if (rd_gidx == A_STAT) rd_data = {{(DW-NWIN){1'b0}}, pend};
        end else begin
            for (int w = 0; w < NWIN; w++)
                if (rd_win == WB'(w)) rd_data = bank_rd[w];
        end
    end

    AST_IDLE_WIN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync) |=> $stable(win_en)); // R6

endmodule

// File: tb/shadow_regs_tb.sv
`timescale 1ns/1ps
module shadow_regs_tb;
    localparam int NWIN = 5, NREG = 4, DW = 32, AW = 6;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, vsync = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic [NWIN*NREG*DW-1:0] win_regs;
    logic [NWIN-1:0] win_en;
    logic video_on;

    int total = 0, bad = 0;

    logic [DW-1:0] m_sh  [NWIN][NREG];
    logic [DW-1:0] m_act [NWIN][NREG];
    logic [NWIN-1:0] m_hold, m_pend;
    logic m_imm, m_fss, m_fsa;

    always #4 clk = ~clk;

    shadow_regs u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .vsync(vsync),
        .win_regs(win_regs), .win_en(win_en), .video_on(video_on));

    function automatic logic [AW-1:0] wa(int w, int r);
        return {1'b0, 3'(w), 2'(r)};
    endfunction
    function automatic logic [AW-1:0] ga(int i);
        return {1'b1, 5'(i)};
    endfunction

    function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
        if (a[5]) begin
            case (a[4:0])
                5'd0: return {30'b0, m_fss, m_imm};
                5'd1: return {27'b0, m_hold};
                5'd2: return {27'b0, m_pend};
                default: return '0;
            endcase
        end
        if (int'(a[4:2]) < NWIN) return m_sh[a[4:2]][a[1:0]];
        return '0;
    endfunction

    task automatic model_reset();
        for (int w = 0; w < NWIN; w++)
            for (int r = 0; r < NREG; r++) begin m_sh[w][r] = '0; m_act[w][r] = '0; end
        m_hold = '0; m_pend = '0; m_imm = 0; m_fss = 0; m_fsa = 0;
    endtask

    task automatic model_step(logic we, logic [AW-1:0] a, logic [DW-1:0] d, logic vs);
        logic [NWIN-1:0] cm;
        for (int w = 0; w < NWIN; w++) begin
            cm[w] = vs && !m_hold[w] && m_pend[w];
            if (cm[w]) for (int r = 0; r < NREG; r++) m_act[w][r] = m_sh[w][r];
            m_pend[w] = m_pend[w] & ~cm[w];
        end
        if (vs) m_fsa = m_fss;
        if (we) begin
            if (a[5]) begin
                if (a[4:0] == 5'd0) begin m_imm = d[0]; m_fss = d[1]; end
                else if (a[4:0] == 5'd1) m_hold = d[4:0];
            end else if (int'(a[4:2]) < NWIN) begin
                m_sh[a[4:2]][a[1:0]] = d;
                m_pend[a[4:2]] = 1'b1;
            end
        end
    endtask

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called just after a negative edge
    task automatic cyc(logic we, logic [AW-1:0] a, logic [DW-1:0] d, logic vs);
        wr_en = we; wr_addr = a; wr_data = d; vsync = vs;
        @(posedge clk);
        model_step(we, a, d, vs);
        @(negedge clk);
        wr_en = 0; vsync = 0;
    endtask

    task automatic rd(string req, logic [AW-1:0] a);
        rd_addr = a; #1;
        chk(req, rd_data, exp_read(a));
    endtask

    task automatic check_outs(string req);
        logic [NWIN-1:0] ee;
        for (int w = 0; w < NWIN; w++) begin
            for (int r = 0; r < NREG; r++)
                chk(req, win_regs[(w*NREG+r)*DW +: DW], m_act[w][r]);
            ee[w] = m_act[w][0][0];
        end
        chk({req, " R6 enable"}, {27'b0, win_en}, {27'b0, ee});
        chk({req, " R9 video"}, {31'b0, video_on}, {31'b0, m_imm & m_fsa});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check_outs("R1");
        for (int i = 0; i < 3; i++) rd("R1", ga(i));
        for (int w = 0; w < NWIN; w++) rd("R1", wa(w, 3));

        // R2 staged write
        cyc(1, wa(1, 2), 32'hA5A5_0102, 0);
        rd("R2", wa(1, 2));
        chk("R2 live untouched", win_regs[(1*NREG+2)*DW +: DW], 32'h0);
        rd("R8 status set", ga(2));
        // R3 commit at sync
        cyc(0, '0, '0, 1);
        chk("R3 commit", win_regs[(1*NREG+2)*DW +: DW], 32'hA5A5_0102);
        rd("R8 status cleared", ga(2));

        // R4 / R5 hold
        cyc(1, ga(1), 32'h4, 0);
        rd("R11 hold readback", ga(1));
        cyc(1, wa(2, 1), 32'h2222_0001, 0);
        cyc(1, wa(3, 1), 32'h3333_0001, 0);
        cyc(0, '0, '0, 1);
        chk("R4 held window", win_regs[(2*NREG+1)*DW +: DW], 32'h0);
        chk("R4 free window", win_regs[(3*NREG+1)*DW +: DW], 32'h3333_0001);
        rd("R8 held pending", ga(2));
        cyc(0, '0, '0, 1);
        chk("R4 still held", win_regs[(2*NREG+1)*DW +: DW], 32'h0);
        cyc(1, ga(1), 32'h0, 0);
        cyc(0, '0, '0, 0);
        chk("R5 no early commit", win_regs[(2*NREG+1)*DW +: DW], 32'h0);
        cyc(0, '0, '0, 1);
        chk("R5 released", win_regs[(2*NREG+1)*DW +: DW], 32'h2222_0001);
        check_outs("R5");

        // R6 enable clear waits for sync
        cyc(1, wa(0, 0), 32'h1, 0);
        cyc(0, '0, '0, 1);
        chk("R6 on", {31'b0, win_en[0]}, 32'h1);
        cyc(1, wa(0, 0), 32'h0, 0);
        chk("R6 still on", {31'b0, win_en[0]}, 32'h1);
        rd("R6 staged off", wa(0, 0));
        cyc(0, '0, '0, 0);
        chk("R6 still on", {31'b0, win_en[0]}, 32'h1);
        cyc(0, '0, '0, 1);
        chk("R6 off", {31'b0, win_en[0]}, 32'h0);

        // R7 write in the sync clock
        cyc(1, wa(4, 3), 32'h4444_7777, 1);
        chk("R7 not this sync", win_regs[(4*NREG+3)*DW +: DW], 32'h0);
        rd("R7 status", ga(2));
        cyc(0, '0, '0, 1);
        chk("R7 next sync", win_regs[(4*NREG+3)*DW +: DW], 32'h4444_7777);

        // R9 global enables
        cyc(1, ga(0), 32'h1, 0);
        chk("R9 imm only", {31'b0, video_on}, 32'h0);
        cyc(1, ga(0), 32'h3, 0);
        chk("R9 sync pending", {31'b0, video_on}, 32'h0);
        rd("R9 ctrl read", ga(0));
        cyc(0, '0, '0, 1);
        chk("R9 on", {31'b0, video_on}, 32'h1);
        cyc(1, ga(0), 32'h0, 0);
        chk("R9 stop", {31'b0, video_on}, 32'h0);

        // R10 ignored writes
        cyc(1, wa(6, 1), 32'hDEAD_BEEF, 0);
        cyc(1, ga(3), 32'hDEAD_BEEF, 0);
        cyc(1, ga(2), 32'hFFFF_FFFF, 0);
        cyc(0, '0, '0, 1);
        rd("R10 bad window", wa(6, 1));
        rd("R10 bad global", ga(3));
        rd("R10 status", ga(2));
        check_outs("R10");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic we, vs;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            we = ($urandom % 2) == 0;
            vs = ($urandom % 6) == 0;
            a  = AW'($urandom);
            if (($urandom % 5) == 0) a = ga($urandom % 3);
            d  = $urandom;
            cyc(we, a, d, vs);
            check_outs("R3 random");
            rd("R8 random", ga(2));
            rd("R11 random", ga(1));
            rd("R2 random", AW'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule